// File: doc/BRIEF.md
# Power-On and Manual Reset Supervisor

This block drives the active-low reset line of a processor. It starts from the power-good flag of the core supply rail and from a push-button request. When the core rail first reports good, the reset stays asserted for a programmable number of millisecond ticks. It is released only if the rail is still good when that count completes. If the rail drops while reset is being held, the count starts again from zero.

A press of the button counts as a manual reset only while a separate qualifier input is high. This keeps a press that is used to power the system on from also resetting the processor. A qualified press asserts reset in the same cycle, with no register in the path. Reset then stays asserted for as long as the button is held. After the button is let go, the full time-out runs again before reset is released.

The reset line is modelled as an open-drain output. There is a pull-down enable and the resulting wire level, which is low when pulled and high through the external pull-up otherwise. The analog detection of the power-good threshold is outside this block.

Top module: `rst_supervisor`

## Requirements
- R1: While the block's own asynchronous reset `rst_n` is low, and directly after it, the reset line is asserted (`cpu_rst_n` = 0, `rst_pull_en` = 1).
- R2: Whenever `rail_ok` is 0, `cpu_rst_n` is 0 in that same cycle.
- R3: Counting starts at the clock edge where `rail_ok` is first sampled 1. `cpu_rst_n` rises right after the edge that samples the TIMEOUT_MS-th `tick_ms` pulse, counting only edges after that start edge, and not before.
- R4: If `rail_ok` goes to 0 while reset is held, the tick count restarts from zero. A full TIMEOUT_MS ticks are then needed after the rail returns.
- R5: `cpu_rst_n` only rises when `rail_ok` was 1 at the clock edge just before the rise.
- R6: When `btn_pressed` and `mr_enable` are both 1, `cpu_rst_n` is 0 in that same cycle.
- R7: After a manual reset, `cpu_rst_n` stays 0 while `btn_pressed` is 1. It rises only after TIMEOUT_MS further ticks, counted from the edge where the release is sampled.
- R8: A press of `btn_pressed` while `mr_enable` is 0 has no effect on `cpu_rst_n` once reset has been released.
- R9: `rst_pull_en` is 1 exactly when `cpu_rst_n` is 0.
- R10: The expired-count event never occurs in a cycle where `rail_ok` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low block reset |
| rail_ok | input | 1 | Power-good of the core rail |
| btn_pressed | input | 1 | Push-button pressed (1 = pressed) |
| mr_enable | input | 1 | Qualifier that allows a press to act as manual reset |
| tick_ms | input | 1 | One-cycle pulse every millisecond |
| rst_pull_en | output | 1 | Open-drain pull-down enable for the reset wire |
| cpu_rst_n | output | 1 | Level of the processor reset wire (active low) |

## Verification
A clean power-up with a tick on every cycle pins down the exact release cycle. A second power-up drops the rail one tick before expiry, which separates a restarted count from a count that merely pauses. A manual press is held across many ticks, which shows whether the count waits for the release or runs during the press. A press with the qualifier low shows that an unqualified press leaves the output alone. Random rail drops, presses, qualifier changes and sparse ticks, checked every cycle against a bench model, then cover the orderings between these events. These include a press arriving during a power-up count and a rail loss during a manual hold.

// File: rtl/supv_pkg.sv
package supv_pkg;
  typedef enum logic [1:0] {
    PH_WAIT_RAIL = 2'd0,
    PH_COUNTING  = 2'd1,
    PH_RUNNING   = 2'd2,
    PH_MANUAL    = 2'd3
  } supv_phase_e;

  // Count value after one cycle: cleared unless counting with a good rail.
  function automatic int unsigned next_count(input int unsigned cur,
                                             input bit counting,
                                             input bit rail,
                                             input bit tick);
    if (!(counting && rail)) return 0;
    if (tick) return cur + 1;
    return cur;
  endfunction

  // Time-out completes on the tick that brings the count to its limit.
  function automatic bit count_done(input int unsigned cur,
                                    input int unsigned limit,
                                    input bit tick);
    return tick && (cur == limit - 1);
  endfunction
endpackage

// File: rtl/supv_timer.sv
module supv_timer #(
  parameter int unsigned TIMEOUT_MS = 16,
  localparam int unsigned CNT_W = $clog2(TIMEOUT_MS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             counting,
  input  logic             rail_ok,
  input  logic             tick_ms,
  output logic [CNT_W-1:0] count_q,
  output logic             expire
);
  import supv_pkg::*;

  logic [CNT_W-1:0] count_d;

  always_comb begin
    count_d = CNT_W'(next_count(int'(count_q), counting, rail_ok, tick_ms));
    expire  = counting && rail_ok && count_done(int'(count_q), TIMEOUT_MS, tick_ms);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) count_q <= '0;
    else        count_q <= count_d;
  end
endmodule

// File: rtl/supv_fsm.sv
module supv_fsm (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  rail_ok,
  input  logic                  btn_pressed,
  input  logic                  mr_req,
  input  logic                  expire,
  output supv_pkg::supv_phase_e phase_q,
  output logic                  counting
);
  import supv_pkg::*;

  supv_phase_e phase_d;

  always_comb begin
    phase_d = phase_q;
    unique case (phase_q)
      PH_WAIT_RAIL: if (rail_ok) phase_d = PH_COUNTING;
      PH_COUNTING: begin
        if (!rail_ok)    phase_d = PH_WAIT_RAIL;
        else if (mr_req) phase_d = PH_MANUAL;
        else if (expire) phase_d = PH_RUNNING;
      end
      PH_RUNNING: begin
        if (!rail_ok)    phase_d = PH_WAIT_RAIL;
        else if (mr_req) phase_d = PH_MANUAL;
      end
      PH_MANUAL: begin
        if (!rail_ok)         phase_d = PH_WAIT_RAIL;
        else if (!btn_pressed) phase_d = PH_COUNTING;
      end
      default: phase_d = PH_WAIT_RAIL;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= PH_WAIT_RAIL;
    else        phase_q <= phase_d;
  end

  assign counting = (phase_q == PH_COUNTING);
endmodule

// File: rtl/supv_odrain.sv
module supv_odrain (
  input  logic hold,
  output logic pull_en,
  output logic line_n
);
  // Pull-down enabled while held; otherwise the external pull-up wins.
  assign pull_en = hold;
  assign line_n  = hold ? 1'b0 : 1'b1;
endmodule

// File: rtl/rst_supervisor.sv
module rst_supervisor #(
  parameter int unsigned TIMEOUT_MS = 16,
  localparam int unsigned CNT_W = $clog2(TIMEOUT_MS + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rail_ok,
  input  logic btn_pressed,
  input  logic mr_enable,
  input  logic tick_ms,
  output logic rst_pull_en,
  output logic cpu_rst_n
);
  import supv_pkg::*;

  supv_phase_e      phase_w;
  logic             counting_w;
  logic             expire_w;
  logic             mr_req_w;
  logic             hold_w;
  logic [CNT_W-1:0] count_w;

  assign mr_req_w = btn_pressed && mr_enable;
  // Output is released only in the running phase, and drops at once on a
  // qualified press or a rail loss, without waiting for a clock edge.
  assign hold_w   = (phase_w != PH_RUNNING) || mr_req_w || !rail_ok;

  supv_timer #(.TIMEOUT_MS(TIMEOUT_MS)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .counting (counting_w),
    .rail_ok  (rail_ok),
    .tick_ms  (tick_ms),
    .count_q  (count_w),
    .expire   (expire_w)
  );

  supv_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .rail_ok     (rail_ok),
    .btn_pressed (btn_pressed),
    .mr_req      (mr_req_w),
    .expire      (expire_w),
    .phase_q     (phase_w),
    .counting    (counting_w)
  );

  supv_odrain u_out (
    .hold    (hold_w),
    .pull_en (rst_pull_en),
    .line_n  (cpu_rst_n)
  );
endmodule

// File: rtl/rst_supervisor_chk.sv
module rst_supervisor_chk #(
  parameter int unsigned CNT_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rail_ok,
  input logic             btn_pressed,
  input logic             mr_enable,
  input logic             rst_pull_en,
  input logic             cpu_rst_n,
  input logic             expire_w,
  input logic [CNT_W-1:0] count_w
);
  always_comb begin
    if (!rst_n) assert_reset_asserted_R1: assert (cpu_rst_n == 1'b0);
  end

  assert_rail_low_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !rail_ok |-> !cpu_rst_n);

  assert_count_restart_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !rail_ok |=> (count_w == '0));

  assert_release_needs_rail_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cpu_rst_n) |-> $past(rail_ok));

  assert_release_after_expiry_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cpu_rst_n) |-> $past(expire_w));

  assert_manual_immediate_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (btn_pressed && mr_enable) |-> !cpu_rst_n);

  assert_pull_matches_line_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rst_pull_en == !cpu_rst_n);

  assert_no_expiry_without_rail_R10: assert property (@(posedge clk) disable iff (!rst_n)
    expire_w |-> rail_ok);
endmodule

bind rst_supervisor rst_supervisor_chk #(.CNT_W(CNT_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .rail_ok     (rail_ok),
  .btn_pressed (btn_pressed),
  .mr_enable   (mr_enable),
  .rst_pull_en (rst_pull_en),
  .cpu_rst_n   (cpu_rst_n),
  .expire_w    (expire_w),
  .count_w     (count_w)
);

// File: tb/tb_rst_supervisor.sv
`timescale 1ns/1ps
module tb_rst_supervisor;
  localparam int unsigned TMO = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rail_ok = 1'b0;
  logic btn_pressed = 1'b0;
  logic mr_enable = 1'b0;
  logic tick_ms = 1'b0;
  logic rst_pull_en;
  logic cpu_rst_n;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;
  string cur_req = "R1";

  always #2.5 clk = ~clk;

  rst_supervisor #(.TIMEOUT_MS(TMO)) dut (
    .clk(clk), .rst_n(rst_n), .rail_ok(rail_ok), .btn_pressed(btn_pressed),
    .mr_enable(mr_enable), .tick_ms(tick_ms),
    .rst_pull_en(rst_pull_en), .cpu_rst_n(cpu_rst_n)
  );

  // Behavioural model: 0 waiting for rail, 1 counting, 2 released, 3 button hold.
  int m_ph = 0;
  int m_cnt = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ph  <= 0;
      m_cnt <= 0;
    end else begin
      case (m_ph)
        0: if (rail_ok) begin m_ph <= 1; m_cnt <= 0; end
        1: begin
          if (!rail_ok) m_ph <= 0;
          else if (btn_pressed && mr_enable) m_ph <= 3;
          else if (tick_ms) begin
            if (m_cnt == TMO - 1) m_ph <= 2;
            else m_cnt <= m_cnt + 1;
          end
        end
        2: begin
          if (!rail_ok) m_ph <= 0;
          else if (btn_pressed && mr_enable) m_ph <= 3;
        end
        default: begin
          if (!rail_ok) m_ph <= 0;
          else if (!btn_pressed) begin m_ph <= 1; m_cnt <= 0; end
        end
      endcase
    end
  end

  function automatic bit exp_line(int ph, bit rail, bit btn, bit en);
    return (ph == 2) && rail && !(btn && en);
  endfunction

  task automatic check(string req, bit act, bit exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%0b expected=%0b at %0t", req, act, exp, $time);
    end
  endtask

  // Continuous comparison against the model, away from the active edge.
  always @(negedge clk) begin
    if (!done) begin
      check(cur_req, cpu_rst_n, exp_line(m_ph, rail_ok, btn_pressed, mr_enable));
      check("R9", rst_pull_en, !cpu_rst_n);
    end
  end

  task automatic cyc(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    n_bad++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    // R1: reset state
    cyc(3);
    check("R1", cpu_rst_n, 1'b0);
    check("R1", rst_pull_en, 1'b1);
    rst_n = 1'b1;
    cyc(1);
    check("R1", cpu_rst_n, 1'b0);

    // R2: rail absent keeps reset asserted even with ticks
    cur_req = "R2";
    tick_ms = 1'b1;
    cyc(40);
    check("R2", cpu_rst_n, 1'b0);

    // R3: exact release cycle, tick every cycle
    cur_req = "R3";
    rail_ok = 1'b1;
    cyc(1);
    cyc(TMO - 1);
    check("R3", cpu_rst_n, 1'b0);
    cyc(1);
    check("R3", cpu_rst_n, 1'b1);

    // R9 / R2: rail loss while running asserts at once
    cur_req = "R2";
    rail_ok = 1'b0;
    #1;
    check("R2", cpu_rst_n, 1'b0);
    check("R9", rst_pull_en, 1'b1);
    cyc(2);

    // R4 / R5: rail drops one tick before expiry; full count needed again
    cur_req = "R4";
    rail_ok = 1'b1;
    cyc(1);
    cyc(TMO - 1);
    rail_ok = 1'b0;
    cyc(1);
    check("R5", cpu_rst_n, 1'b0);
    rail_ok = 1'b1;
    cyc(1);
    cyc(TMO - 1);
    check("R4", cpu_rst_n, 1'b0);
    cyc(1);
    check("R4", cpu_rst_n, 1'b1);

    // R8: unqualified press leaves the line released
    cur_req = "R8";
    mr_enable = 1'b0;
    btn_pressed = 1'b1;
    cyc(5);
    check("R8", cpu_rst_n, 1'b1);
    btn_pressed = 1'b0;
    cyc(1);

    // R6 / R7: qualified press, held across many ticks
    cur_req = "R7";
    mr_enable = 1'b1;
    btn_pressed = 1'b1;
    #1;
    check("R6", cpu_rst_n, 1'b0);
    cyc(3 * TMO);
    check("R7", cpu_rst_n, 1'b0);
    btn_pressed = 1'b0;
    cyc(1);
    cyc(TMO - 1);
    check("R7", cpu_rst_n, 1'b0);
    cyc(1);
    check("R7", cpu_rst_n, 1'b1);

    // Random mix, seeded
    cur_req = "R3";
    void'($urandom(32'h5eed_0042));
    for (int i = 0; i < 6000; i++) begin
      if ($urandom_range(99) < 2) rail_ok = ~rail_ok;
      if ($urandom_range(99) < 4) btn_pressed = ~btn_pressed;
      if ($urandom_range(99) < 3) mr_enable = ~mr_enable;
      tick_ms = ($urandom_range(99) < 35);
      cyc(1);
    end

    cyc(2);
    finish_run();
  end
endmodule